// File: doc/BRIEF.md
# Floating/Integer Register Bit-Move Unit

This block copies raw IEEE 754 bit patterns between the 64-bit value of a floating-point register and the 64-bit value of an integer register. It does no arithmetic. A direction bit picks float-to-integer or integer-to-float. A precision bit picks double or single. In double mode all 64 bits pass through unchanged. In single mode the unit narrows the 64-bit register format to the 32-bit storage format, or widens storage format back to register format, using the same bit rules as single-precision stores and loads. It never rounds.

Each accepted operation produces a registered result one clock later. When the record bit is set, the unit also produces a 4-bit condition-field update with a write strobe. For moves into the integer side, the field is condition field 0 and is computed from the signed 64-bit result. For moves into the floating side, the field is condition field 1 and carries the four floating-point exception summary bits supplied on an input port. The unit reads and writes no floating-point status.

Top module: `fgmove_unit`

## Requirements
- R1: When `in_valid` is 1 and `is_single` is 0, `res_data` in the next cycle equals `src_data` in both directions, and `out_valid` is 1 exactly one cycle after `in_valid`.
- R2: Single move to integer (`to_gpr`=1, `is_single`=1): `res_data[63:32]`=0, bit 31 = source bit 63, bits 30:23 = {source bit 62, source bits 58:52}, bits 22:0 = source bits 51:29, with no rounding.
- R3: Single move from integer with a normal input (exponent 1..254): only `src_data[31:0]` is used. The result holds the sign, the exponent plus 896 in bits 62:52, and the 23 fraction bits in bits 51:29, with zeros in bits 28:0.
- R4: Single move from integer with an input exponent of 255: the result exponent is 2047 and the fraction is kept in bits 51:29, so infinities and NaN payloads are preserved.
- R5: Single move from integer with an input exponent of 0: a zero fraction gives a signed zero. A nonzero fraction is normalized into a double normal whose exponent is 896 minus the count of leading zeros of the 23-bit fraction. The fraction is the remaining bits below the leading one, left-aligned.
- R6: With `rc_en`=1 and `to_gpr`=1, `cr_wen`=1, `cr_idx`=0, and `cr_val` = {LT,GT,EQ,SO} as bits 3..0. LT/GT/EQ come from the signed 64-bit result compared with zero, and SO = `so_in`.
- R7: With `rc_en`=1 and `to_gpr`=0, `cr_wen`=1, `cr_idx`=1, and `cr_val` equals `fp_summary`.
- R8: With `rc_en`=0, or when no operation is accepted, `cr_wen` is 0 in the output cycle. Outputs other than `out_valid` and `cr_wen` hold their last values when no operation is accepted.
- R9: After synchronous reset, `out_valid`, `cr_wen`, `cr_idx`, `cr_val` and `res_data` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation accepted this cycle |
| to_gpr | input | 1 | 1: float to integer side, 0: integer to float side |
| is_single | input | 1 | 1: single-precision move, 0: double |
| rc_en | input | 1 | Request a condition-field update |
| src_data | input | 64 | Source register value |
| so_in | input | 1 | Summary overflow bit copied into condition field 0 |
| fp_summary | input | 4 | Exception summary bits for condition field 1 |
| out_valid | output | 1 | Result valid |
| res_data | output | 64 | Moved bit pattern |
| cr_wen | output | 1 | Condition-field write strobe |
| cr_idx | output | 3 | Index of the condition field to write |
| cr_val | output | 4 | Condition-field value |

## Verification
The bench runs a behavioural model and compares every output on every clock. A wrong bit in the narrowing or widening path, or a wrong condition encoding, shows at the ports in the cycle right after the operation is accepted. A bad leading-zero count on single denormals shows as a wrong exponent and fraction in that same cycle. A stale hold register or a stuck strobe shows up as a mismatch on the next idle cycle. Directed corner values (infinities, NaN payloads, signed zeros, the smallest and largest denormals, negative and zero integer results) are mixed with a pseudo-random stream.

// File: rtl/fgm_pkg.sv
package fgm_pkg;
  parameter int DW        = 64;
  parameter int SW        = 32;
  parameter int DEXP_W    = 11;
  parameter int SEXP_W    = 8;
  parameter int DFRAC_W   = 52;
  parameter int SFRAC_W   = 23;
  parameter int CR_W      = 4;
  parameter int CR_IDX_W  = 3;
  parameter int CR_GPR_ID = 0;
  parameter int CR_FPR_ID = 1;
  localparam int BIAS_DIFF = (1 << (DEXP_W - 1)) - (1 << (SEXP_W - 1));
  localparam int PAD_W     = DFRAC_W - SFRAC_W;
  localparam int LZ_W      = $clog2(SFRAC_W + 1);
endpackage

// File: rtl/fgm_narrow.sv
module fgm_narrow
  import fgm_pkg::*;
(
  input  logic [DW-1:0] dbl_in,
  output logic [DW-1:0] word_out
);
  logic              sgn;
  logic [SEXP_W-1:0] e8;
  logic [SFRAC_W-1:0] f23;
  logic unused_bits;

  assign sgn = dbl_in[DW-1];
  assign e8  = {dbl_in[DW-2], dbl_in[DFRAC_W+SEXP_W-2:DFRAC_W]};
  assign f23 = dbl_in[DFRAC_W-1 -: SFRAC_W];
  assign unused_bits = ^{dbl_in[DW-3:DFRAC_W+SEXP_W-1], dbl_in[PAD_W-1:0]};

  assign word_out = {{(DW-SW){1'b0}}, sgn, e8, f23};
endmodule

// File: rtl/fgm_widen.sv
module fgm_widen
  import fgm_pkg::*;
(
  input  logic [SW-1:0] word_in,
  output logic [DW-1:0] dbl_out
);
  logic               sgn;
  logic [SEXP_W-1:0]  e8;
  logic [SFRAC_W-1:0] f23;
  logic [LZ_W-1:0]    lz;
  logic [LZ_W-1:0]    shamt;
  logic [SFRAC_W-1:0] norm_f;
  logic               hit;

  assign sgn = word_in[SW-1];
  assign e8  = word_in[SW-2 -: SEXP_W];
  assign f23 = word_in[SFRAC_W-1:0];

  always_comb begin
    lz  = LZ_W'(SFRAC_W);
    hit = 1'b0;
    for (int i = SFRAC_W - 1; i >= 0; i--) begin
      if (!hit && f23[i]) begin
        lz  = LZ_W'(SFRAC_W - 1 - i);
        hit = 1'b1;
      end
    end
  end

  assign shamt  = lz + LZ_W'(1);
  assign norm_f = f23 << shamt;

  always_comb begin
    if (e8 == {SEXP_W{1'b1}})
      dbl_out = {sgn, {DEXP_W{1'b1}}, f23, {PAD_W{1'b0}}};
    else if (e8 != '0)
      dbl_out = {sgn, DEXP_W'(e8) + DEXP_W'(BIAS_DIFF), f23, {PAD_W{1'b0}}};
    else if (f23 == '0)
      dbl_out = {sgn, {(DW-1){1'b0}}};
    else
      dbl_out = {sgn, DEXP_W'(BIAS_DIFF) - DEXP_W'(lz), norm_f, {PAD_W{1'b0}}};
  end
endmodule

// File: rtl/fgm_crgen.sv
module fgm_crgen
  import fgm_pkg::*;
(
  input  logic [DW-1:0]       val,
  input  logic                to_gpr,
  input  logic                so_in,
  input  logic [CR_W-1:0]     fp_summary,
  output logic [CR_W-1:0]     cr_val,
  output logic [CR_IDX_W-1:0] cr_idx
);
  logic neg, zero;
  assign neg  = val[DW-1];
  assign zero = (val == '0);

  always_comb begin
    if (to_gpr) begin
      cr_val = {neg, !neg && !zero, zero, so_in};
      cr_idx = CR_IDX_W'(CR_GPR_ID);
    end else begin
      cr_val = fp_summary;
      cr_idx = CR_IDX_W'(CR_FPR_ID);
    end
  end
endmodule

// File: rtl/fgmove_unit.sv
module fgmove_unit
  import fgm_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic                to_gpr,
  input  logic                is_single,
  input  logic                rc_en,
  input  logic [DW-1:0]       src_data,
  input  logic                so_in,
  input  logic [CR_W-1:0]     fp_summary,
  output logic                out_valid,
  output logic [DW-1:0]       res_data,
  output logic                cr_wen,
  output logic [CR_IDX_W-1:0] cr_idx,
  output logic [CR_W-1:0]     cr_val
);
  logic [DW-1:0]       narrowed, widened, moved;
  logic [CR_W-1:0]     cr_val_c;
  logic [CR_IDX_W-1:0] cr_idx_c;
  logic                r_single, r_to_gpr;

  fgm_narrow u_narrow (.dbl_in(src_data), .word_out(narrowed));
  fgm_widen  u_widen  (.word_in(src_data[SW-1:0]), .dbl_out(widened));

  always_comb begin
    if (!is_single)  moved = src_data;
    else if (to_gpr) moved = narrowed;
    else             moved = widened;
  end

  fgm_crgen u_crgen (
    .val(moved), .to_gpr(to_gpr), .so_in(so_in), .fp_summary(fp_summary),
    .cr_val(cr_val_c), .cr_idx(cr_idx_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      cr_wen    <= 1'b0;
      res_data  <= '0;
      cr_idx    <= '0;
      cr_val    <= '0;
      r_single  <= 1'b0;
      r_to_gpr  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      cr_wen    <= in_valid && rc_en;
      if (in_valid) begin
        res_data <= moved;
        r_single <= is_single;
        r_to_gpr <= to_gpr;
        if (rc_en) begin
          cr_idx <= cr_idx_c;
          cr_val <= cr_val_c;
        end
      end
    end
  end

  p_latency_r1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid && !cr_wen);
  p_dbl_pass_r1: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !is_single) |=> res_data == $past(src_data));
  p_upper_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (out_valid && r_single && r_to_gpr) |-> res_data[DW-1:SW] == '0);
  p_cr0_onehot_r6: assert property (@(posedge clk) disable iff (rst)
    (cr_wen && cr_idx == CR_IDX_W'(CR_GPR_ID)) |-> $onehot(cr_val[CR_W-1:1]));
  p_cr1_copy_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && rc_en && !to_gpr) |=> cr_val == $past(fp_summary));
  p_wen_qual_r8: assert property (@(posedge clk) disable iff (rst)
    cr_wen |-> out_valid);
endmodule

// File: tb/fgmove_unit_bench.sv
`timescale 1ns/1ps
module fgmove_unit_bench;
  logic clk = 0, rst = 1;
  logic in_valid = 0, to_gpr = 0, is_single = 0, rc_en = 0, so_in = 0;
  logic [63:0] src_data = '0;
  logic [3:0]  fp_summary = '0;
  logic        out_valid, cr_wen;
  logic [63:0] res_data;
  logic [2:0]  cr_idx;
  logic [3:0]  cr_val;

  always #2 clk = ~clk;

  fgmove_unit u_fgmove_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .to_gpr(to_gpr),
    .is_single(is_single), .rc_en(rc_en), .src_data(src_data), .so_in(so_in),
    .fp_summary(fp_summary), .out_valid(out_valid), .res_data(res_data),
    .cr_wen(cr_wen), .cr_idx(cr_idx), .cr_val(cr_val)
  );

  int compared = 0, mismatched = 0;
  bit done = 0;

  // reference state
  logic        m_valid = 0, m_wen = 0;
  logic [63:0] m_res = 0;
  logic [2:0]  m_idx = 0;
  logic [3:0]  m_val = 0;
  string       m_tag = "R9", m_ctag = "R9";

  function automatic logic [63:0] ref_widen(input logic [31:0] w);
    longint unsigned mant;
    int e;
    e = int'(w[30:23]);
    mant = longint'(w[22:0]);
    if (e == 255) return {w[31], 11'h7FF, w[22:0], 29'd0};
    if (e != 0) return {w[31], 11'(e - 127 + 1023), w[22:0], 29'd0};
    if (mant == 0) return {w[31], 63'd0};
    e = -126;
    while (mant < 64'h800000) begin mant = mant * 2; e = e - 1; end
    return {w[31], 11'(e + 1023), mant[22:0], 29'd0};
  endfunction

  function automatic logic [63:0] ref_move(input logic tg, input logic sg, input logic [63:0] s);
    if (!sg) return s;
    if (tg) return {32'd0, s[63], s[62], s[58:52], s[51:29]};
    return ref_widen(s[31:0]);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_valid <= 0; m_wen <= 0; m_res <= 0; m_idx <= 0; m_val <= 0;
      m_tag <= "R9"; m_ctag <= "R9";
    end else begin
      m_valid <= in_valid;
      m_wen   <= in_valid && rc_en;
      m_ctag  <= (in_valid && rc_en) ? (to_gpr ? "R6" : "R7") : "R8";
      if (in_valid) begin
        logic [63:0] r;
        r = ref_move(to_gpr, is_single, src_data);
        m_res <= r;
        if (!is_single) m_tag <= "R1";
        else if (to_gpr) m_tag <= "R2";
        else if (src_data[30:23] == 8'hFF) m_tag <= "R4";
        else if (src_data[30:23] == 8'h00) m_tag <= "R5";
        else m_tag <= "R3";
        if (rc_en) begin
          if (to_gpr) begin
            m_idx <= 3'd0;
            m_val <= {$signed(r) < 0, $signed(r) > 0, r == 0, so_in};
          end else begin
            m_idx <= 3'd1;
            m_val <= fp_summary;
          end
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      compared++;
      if (out_valid !== m_valid || res_data !== m_res) begin
        mismatched++;
        $display("FAIL %s: valid/result got %0b/%h expected %0b/%h", m_tag, out_valid, res_data, m_valid, m_res);
      end
      compared++;
      if (cr_wen !== m_wen || cr_idx !== m_idx || cr_val !== m_val) begin
        mismatched++;
        $display("FAIL %s: wen/idx/val got %0b/%0d/%b expected %0b/%0d/%b", m_ctag, cr_wen, cr_idx, cr_val, m_wen, m_idx, m_val);
      end
    end
  end

  task automatic op(input logic tg, input logic sg, input logic rc, input logic [63:0] s,
                    input logic so, input logic [3:0] fs);
    @(posedge clk); #1;
    in_valid = 1; to_gpr = tg; is_single = sg; rc_en = rc;
    src_data = s; so_in = so; fp_summary = fs;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      in_valid = 0; src_data = 64'hDEAD_BEEF_0BAD_F00D; rc_en = 1;
    end
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    #400000;
    mismatched++;
    $display("FAIL watchdog: got hang expected completion");
    finish_run();
  end

  initial begin
    logic [63:0] lfsr;
    lfsr = 64'h1234_5678_9ABC_DEF1;
    repeat (3) @(posedge clk);
    #1 rst = 0;                                   // R9 state checked during reset
    idle(2);
    op(1, 0, 0, 64'hC00921FB_54442D18, 0, 0);     // R1 double to int
    op(0, 0, 1, 64'h7FF80000_00000001, 0, 4'b1010); // R1 and R7
    op(1, 1, 0, 64'h3FF00000_00000000, 0, 0);     // R2 1.0
    op(1, 1, 1, 64'hBFD5_5555_5555_5555, 1, 0);   // R2 truncating, R6
    op(0, 1, 0, 64'hFFFF_FFFF_3F80_0000, 0, 0);   // R3 upper bits ignored
    op(0, 1, 0, 64'h0000_0000_C148_0000, 0, 0);   // R3 negative
    op(0, 1, 0, 64'h0000_0000_7F80_0000, 0, 0);   // R4 +inf
    op(0, 1, 1, 64'h1234_5678_FFC0_0123, 0, 4'b0101); // R4 NaN payload, R7
    op(0, 1, 0, 64'h0000_0000_8000_0000, 0, 0);   // R5 -0
    op(0, 1, 0, 64'h0000_0000_0000_0001, 0, 0);   // R5 smallest denormal
    op(0, 1, 0, 64'h0000_0000_807F_FFFF, 0, 0);   // R5 largest denormal
    op(1, 0, 1, 64'h0000_0000_0000_0000, 1, 0);   // R6 EQ
    op(1, 0, 1, 64'h8000_0000_0000_0000, 0, 0);   // R6 LT
    op(1, 0, 1, 64'h0000_0000_0000_0005, 0, 0);   // R6 GT
    op(1, 1, 1, 64'hC000_0000_0000_0000, 0, 0);   // R6 single never negative
    op(1, 0, 0, 64'h1, 1, 4'hF);                  // R8 no rc
    idle(3);                                      // R8 hold
    for (int i = 0; i < 300; i++) begin
      lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
      if (lfsr[7:5] == 0) idle(1);
      else op(lfsr[0], lfsr[1], lfsr[2], lfsr * 64'h9E37_79B9_7F4A_7C15, lfsr[3], lfsr[11:8]);
    end
    idle(2);
    @(posedge clk); #1 rst = 1;                   // R9 again
    idle(2);
    @(negedge clk); #1;
    finish_run();
  end
endmodule